// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns addresses that arrive from PCI bus masters during DMA into system memory addresses. Software programs four windows, each made of a base, a size mask and a translated base. An address that falls inside an enabled window is either relocated directly, or looked up through a single-level page table in system memory (scatter-gather). Addresses wider than 32 bits, which come from double address cycles, take one of two separate paths. One is a large region that maps straight through to memory. The other is a scatter-gather path owned by the last window.

A requester presents an address with a valid strobe. The block then stays busy until it presents a one-cycle result carrying hit or fault, the translated address and the page mask. When a page table entry is needed, the block issues a single 64-bit read with a valid/ready request and waits for the response data. Only one translation is in flight at a time.

The controller is a five-state machine:
- IDLE accepts a request and moves to LOOKUP.
- LOOKUP decodes the address against the windows. A direct hit or a fault moves to RESP. A scatter-gather hit moves to FETCH.
- FETCH holds the memory request until it is accepted, then moves to WAIT.
- WAIT takes the entry when the read data returns and moves to RESP.
- RESP presents the result for one cycle and returns to IDLE.

Top module: `dxl_xlate`

## Requirements
- R1: Register offsets. Window n has its base at n*0x40, its mask at 0x100+n*0x40 and its translated base at 0x200+n*0x40. Control sits at 0x300. Reads at any other offset return 0 and writes there change nothing. Bases 0–2 keep write bits 31:20 and 1:0. Base 3 keeps bits 39, 31:20 and 0, and always reads bit 1 as 1. Masks keep bits 31:20. Translated bases keep bits 34:10. Control keeps the bits under 0x1CFF0FC7FF. After reset every register reads 0, except base 3, which reads 0x2.
- R2: For an address at or below 0xFFFFFFFF, a window hits only when its base bit 0 is set and (addr AND NOT(mask OR 0xFFFFF)) equals base bits 31:20 placed at bits 31:20.
- R3: A hit on a window whose base bit 1 is clear is direct. It returns hit with address (tba AND NOT ext) OR (addr AND ext) and page mask ext, where ext = mask OR 0xFFFFF.
- R4: A hit with base bit 1 set issues one memory read at (tba AND NOT(mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). The request stays valid, with a stable address, until ready is seen.
- R5: A fetched entry with bit 0 set gives hit with address ((entry AND 0x3FFFFE)<<12) OR (addr AND 0x1FFF) and page mask 0x1FFF. An entry with bit 0 clear gives a fault.
- R6: With control bit 5 set, a 32-bit address from 0x80000 to 0xFFFFF faults even when a window covers it. Addresses just outside that range are unaffected.
- R7: Windows 0, 1 and 2 are tried in that order, and the lowest hitting one wins. Window 3 is tried last, and only when its base bit 39 is clear.
- R8: An address from 0x100_0000_0000 to 0x1FF_FFFF_FFFF returns hit with address (addr AND 0x7FFFFFFFF) and page mask 0x7FFFFFFFF when control bit 6 is set. It faults when that bit is clear.
- R9: An address from 0x800_0000_0000 to 0xFFF_FFFF_FFFF takes the window 3 table when base 3 has bits 39 and 0 both set. The entry address is (tba3 AND 0x7FFC00000) OR ((addr AND 0xFFFFE000)>>10), and the entry is then handled as in R5. Otherwise the address faults.
- R10: Any other address faults. A fault reports hit 0, address 0 and page mask 0.
- R11: Busy rises on the cycle after a request is accepted. It stays high through the one-cycle result and falls right after it. Requests presented while busy are ignored. A direct hit or fault is presented two cycles after acceptance.
- R12: Out of reset, busy, the result strobe and the memory request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Read data for the register at cfg_addr (combinational) |
| xl_valid | input | 1 | Translation request strobe |
| xl_addr | input | 64 | PCI DMA address to translate |
| xl_busy | output | 1 | Translation in flight |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_hit | output | 1 | 1 = translated, 0 = fault |
| rsp_paddr | output | 64 | Translated system address |
| rsp_mask | output | 64 | Page mask of the mapping |
| mem_req_valid | output | 1 | Page table read request |
| mem_req_ready | input | 1 | Page table read accepted |
| mem_req_addr | output | 64 | Page table entry address |
| mem_rsp_valid | input | 1 | Page table read data valid |
| mem_rsp_data | input | 64 | Page table entry |

## Verification
The bench probes the address-range edges. These include the last address inside the hole next to the first one outside it, 64-bit addresses on each side of the two double-cycle regions, and a window 3 whose bit 39 moves it from the 32-bit path to the 64-bit one. A design with a wrong range compare would translate an address that should fault, or the reverse. Overlapping windows show whether priority runs the right way: reversed priority returns the higher window's translated base. Entries with bit 0 cleared catch a valid-bit check that is missing. Back-pressure on the memory request and requests pushed while busy catch a controller that drops its request, issues two fetches or accepts a second address.

// File: rtl/dxl_pkg.sv
`timescale 1ns/1ps
package dxl_pkg;
    localparam int unsigned XW = 64;

    // write-keep masks
    localparam logic [XW-1:0] KEEP_BASE      = 64'h0000_0000_FFF0_0003;
    localparam logic [XW-1:0] KEEP_BASE_LAST = 64'h0000_0080_FFF0_0001;
    localparam logic [XW-1:0] FORCE_SG       = 64'h0000_0000_0000_0002;
    localparam logic [XW-1:0] KEEP_MASK      = 64'h0000_0000_FFF0_0000;
    localparam logic [XW-1:0] KEEP_TBA       = 64'h0000_0007_FFFF_FC00;
    localparam logic [XW-1:0] KEEP_CTL       = 64'h0000_001C_FF0F_C7FF;

    // translation constants
    localparam logic [XW-1:0] LOW_EXT        = 64'h0000_0000_000F_FFFF;
    localparam logic [XW-1:0] SG_INDEX       = 64'h0000_0000_000F_E000;
    localparam logic [XW-1:0] PTE_FRAME      = 64'h0000_0000_003F_FFFE;
    localparam logic [XW-1:0] PAGE_MASK      = 64'h0000_0000_0000_1FFF;
    localparam logic [XW-1:0] WIDE_DIRECT    = 64'h0000_0007_FFFF_FFFF;
    localparam logic [XW-1:0] WIDE_TBA_KEEP  = 64'h0000_0007_FFC0_0000;
    localparam logic [XW-1:0] WIDE_INDEX     = 64'h0000_0000_FFFF_E000;
    localparam logic [XW-1:0] HOLE_LO        = 64'h0000_0000_0008_0000;
    localparam logic [XW-1:0] HOLE_HI        = 64'h0000_0000_000F_FFFF;

    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_SG   = 1;
    localparam int unsigned BIT_WIDE = 39;
    localparam int unsigned BIT_HOLE = 5;
    localparam int unsigned BIT_PASS = 6;

    typedef enum logic [1:0] {
        K_MISS   = 2'd0,
        K_DIRECT = 2'd1,
        K_TABLE  = 2'd2
    } kind_t;

    typedef struct packed {
        kind_t          kind;
        logic [XW-1:0]  addr;   // final address (direct) or entry address (table)
        logic [XW-1:0]  mask;
    } route_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LOOKUP = 3'd1,
        S_FETCH  = 3'd2,
        S_WAIT   = 3'd3,
        S_RESP   = 3'd4
    } state_t;
endpackage

// File: rtl/dxl_regs.sv
`timescale 1ns/1ps
module dxl_regs
    import dxl_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned CFG_AW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [XW-1:0]     wdata,
    output logic [XW-1:0]     rdata,
    output logic [XW-1:0]     win_base [NUM_WIN],
    output logic [XW-1:0]     win_mask [NUM_WIN],
    output logic [XW-1:0]     win_tba  [NUM_WIN],
    output logic [XW-1:0]     ctl
);
    localparam int unsigned STRIDE   = 64;
    localparam int unsigned GRP_SPAN = 256;
    localparam int unsigned OFS_MASK = GRP_SPAN;
    localparam int unsigned OFS_TBA  = 2 * GRP_SPAN;
    localparam int unsigned OFS_CTL  = 3 * GRP_SPAN;

    function automatic logic hit_ofs(input logic [CFG_AW-1:0] a, input int unsigned ofs);
        return a == CFG_AW'(ofs);
    endfunction

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [XW-1:0] BKEEP  = (g == NUM_WIN - 1) ? KEEP_BASE_LAST : KEEP_BASE;
        localparam logic [XW-1:0] BFORCE = (g == NUM_WIN - 1) ? FORCE_SG : '0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_base[g] <= BFORCE;
                win_mask[g] <= '0;
                win_tba[g]  <= '0;
            end else if (wr_en) begin
                if (hit_ofs(addr, g * STRIDE))
                    win_base[g] <= (wdata & BKEEP) | BFORCE;
                if (hit_ofs(addr, OFS_MASK + g * STRIDE))
                    win_mask[g] <= wdata & KEEP_MASK;
                if (hit_ofs(addr, OFS_TBA + g * STRIDE))
                    win_tba[g]  <= wdata & KEEP_TBA;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr_en && hit_ofs(addr, OFS_CTL))
            ctl <= wdata & KEEP_CTL;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit_ofs(addr, i * STRIDE))            rdata = win_base[i];
            if (hit_ofs(addr, OFS_MASK + i * STRIDE)) rdata = win_mask[i];
            if (hit_ofs(addr, OFS_TBA + i * STRIDE))  rdata = win_tba[i];
        end
        if (hit_ofs(addr, OFS_CTL)) rdata = ctl;
    end
endmodule

// File: rtl/dxl_win.sv
`timescale 1ns/1ps
module dxl_win
    import dxl_pkg::*;
(
    input  logic [XW-1:0] base,
    input  logic [XW-1:0] mask,
    input  logic [XW-1:0] tba,
    input  logic [XW-1:0] addr,
    output logic          hit,
    output logic          sg,
    output logic [XW-1:0] xaddr,
    output logic [XW-1:0] xmask
);
    logic [XW-1:0] ext;
    logic [XW-1:0] direct_addr;
    logic [XW-1:0] entry_addr;

    always_comb begin
        ext         = mask | LOW_EXT;
        hit         = base[BIT_EN] && ((addr & ~ext) == (base & KEEP_MASK));
        sg          = base[BIT_SG];
        direct_addr = (tba & ~ext) | (addr & ext);
        entry_addr  = (tba & ~(mask >> 10)) | ((addr & (mask | SG_INDEX)) >> 10);
        xaddr       = sg ? entry_addr : direct_addr;
        xmask       = sg ? PAGE_MASK : ext;
    end
endmodule

// File: rtl/dxl_route.sv
`timescale 1ns/1ps
module dxl_route
    import dxl_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4
) (
    input  logic [XW-1:0] addr,
    input  logic          hole_en,
    input  logic          pass_en,
    input  logic [XW-1:0] win_base [NUM_WIN],
    input  logic [XW-1:0] win_mask [NUM_WIN],
    input  logic [XW-1:0] win_tba  [NUM_WIN],
    output route_t        route
);
    localparam int unsigned LAST = NUM_WIN - 1;
    localparam int unsigned IDXW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [NUM_WIN-1:0] w_hit, w_sg, usable;
    logic [XW-1:0]      w_addr [NUM_WIN];
    logic [XW-1:0]      w_mask [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_w
        dxl_win u_win (
            .base  (win_base[g]),
            .mask  (win_mask[g]),
            .tba   (win_tba[g]),
            .addr  (addr),
            .hit   (w_hit[g]),
            .sg    (w_sg[g]),
            .xaddr (w_addr[g]),
            .xmask (w_mask[g])
        );
        if (g == LAST) begin : g_last
            assign usable[g] = w_hit[g] && !win_base[g][BIT_WIDE];
        end else begin : g_norm
            assign usable[g] = w_hit[g];
        end
    end

    logic            found;
    logic [IDXW-1:0] sel;
    logic            narrow, in_hole, pass_range, wide_range;
    logic [XW-1:0]   wide_entry;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (usable[i]) begin
                found = 1'b1;
                sel   = IDXW'(i);
            end
        end
    end

    always_comb begin
        narrow     = addr[63:32] == '0;
        in_hole    = hole_en && addr >= HOLE_LO && addr <= HOLE_HI;
        pass_range = addr[63:40] == 24'h1;
        wide_range = addr[63:43] == 21'h1;
        wide_entry = (win_tba[LAST] & WIDE_TBA_KEEP) | ((addr & WIDE_INDEX) >> 10);

        route.kind = K_MISS;
        route.addr = '0;
        route.mask = '0;
        if (narrow) begin
            if (!in_hole && found) begin
                route.kind = w_sg[sel] ? K_TABLE : K_DIRECT;
                route.addr = w_addr[sel];
                route.mask = w_mask[sel];
            end
        end else if (pass_range && pass_en) begin
            route.kind = K_DIRECT;
            route.addr = addr & WIDE_DIRECT;
            route.mask = WIDE_DIRECT;
        end else if (wide_range && win_base[LAST][BIT_WIDE] && win_base[LAST][BIT_EN]) begin
            route.kind = K_TABLE;
            route.addr = wide_entry;
            route.mask = PAGE_MASK;
        end
    end
endmodule

// File: rtl/dxl_xlate.sv
`timescale 1ns/1ps
module dxl_xlate
    import dxl_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned CFG_AW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic              xl_valid,
    input  logic [63:0]       xl_addr,
    output logic              xl_busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [63:0]       rsp_paddr,
    output logic [63:0]       rsp_mask,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    logic [XW-1:0] win_base [NUM_WIN];
    logic [XW-1:0] win_mask [NUM_WIN];
    logic [XW-1:0] win_tba  [NUM_WIN];
    logic [XW-1:0] ctl;
    route_t        route;

    dxl_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .win_base (win_base),
        .win_mask (win_mask),
        .win_tba  (win_tba),
        .ctl      (ctl)
    );

    state_t        state, state_nx;
    logic [XW-1:0] addr_q, entry_q, paddr_q, mask_q;
    logic          hit_q;

    dxl_route #(.NUM_WIN(NUM_WIN)) u_route (
        .addr     (addr_q),
        .hole_en  (ctl[BIT_HOLE]),
        .pass_en  (ctl[BIT_PASS]),
        .win_base (win_base),
        .win_mask (win_mask),
        .win_tba  (win_tba),
        .route    (route)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (xl_valid)      state_nx = S_LOOKUP;
            S_LOOKUP: state_nx = (route.kind == K_TABLE) ? S_FETCH : S_RESP;
            S_FETCH:  if (mem_req_ready) state_nx = S_WAIT;
            S_WAIT:   if (mem_rsp_valid) state_nx = S_RESP;
            S_RESP:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            entry_q <= '0;
            paddr_q <= '0;
            mask_q  <= '0;
            hit_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (xl_valid) addr_q <= xl_addr;
                S_LOOKUP: begin
                    entry_q <= route.addr;
                    hit_q   <= route.kind == K_DIRECT;
                    paddr_q <= (route.kind == K_DIRECT) ? route.addr : '0;
                    mask_q  <= (route.kind == K_DIRECT) ? route.mask : '0;
                end
                S_WAIT: if (mem_rsp_valid) begin
                    hit_q   <= mem_rsp_data[0];
                    paddr_q <= mem_rsp_data[0]
                             ? (((mem_rsp_data & PTE_FRAME) << 12) | (addr_q & PAGE_MASK)) : '0;
                    mask_q  <= mem_rsp_data[0] ? PAGE_MASK : '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        xl_busy       = state != S_IDLE;
        mem_req_valid = state == S_FETCH;
        mem_req_addr  = entry_q;
        rsp_valid     = state == S_RESP;
        rsp_hit       = hit_q;
        rsp_paddr     = paddr_q;
        rsp_mask      = mask_q;
    end
endmodule

// File: rtl/dxl_chk.sv
`timescale 1ns/1ps
module dxl_chk #(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned CFG_AW  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [63:0]       cfg_rdata,
    input logic              xl_busy,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [63:0]       rsp_paddr,
    input logic [63:0]       rsp_mask,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [63:0]       mem_req_addr
);
    localparam logic [CFG_AW-1:0] LAST_BASE = CFG_AW'((NUM_WIN - 1) * 64);

    // R1: last window base always reads with its table bit set
    a_r1_last_table: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == LAST_BASE) |-> cfg_rdata[1]);

    // R4: request held with stable address until accepted
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: a fault carries zero address and mask
    a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_mask == '0));

    // R11: result lasts one cycle, while busy, and busy drops right after
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !xl_busy));

    a_r11_rsp_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> xl_busy);

    // R12: nothing issued while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_busy |-> (!mem_req_valid && !rsp_valid));
endmodule

bind dxl_xlate dxl_chk #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_addr      (cfg_addr),
    .cfg_rdata     (cfg_rdata),
    .xl_busy       (xl_busy),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_paddr     (rsp_paddr),
    .rsp_mask      (rsp_mask),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_dxl_xlate.sv
`timescale 1ns/1ps
module sim_dxl_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        xl_valid = 1'b0;
    logic [63:0] xl_addr = '0;
    logic        xl_busy, rsp_valid, rsp_hit;
    logic [63:0] rsp_paddr, rsp_mask;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    dxl_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xl_valid(xl_valid),
        .xl_addr(xl_addr), .xl_busy(xl_busy), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench copy of programmed registers (kept per R1)
    logic [63:0] sh_base [4];
    logic [63:0] sh_mask [4];
    logic [63:0] sh_tba  [4];
    logic [63:0] sh_ctl;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a < 12'h100 && a[5:0] == 0)
            sh_base[a[7:6]] = (a[7:6] == 2'd3) ? ((d & 64'h80_FFF0_0001) | 64'h2) : (d & 64'hFFF0_0003);
        else if (a < 12'h200 && a[5:0] == 0) sh_mask[a[7:6]] = d & 64'hFFF0_0000;
        else if (a < 12'h300 && a[5:0] == 0) sh_tba[a[7:6]]  = d & 64'h7_FFFF_FC00;
        else if (a == 12'h300)               sh_ctl          = d & 64'h1C_FF0F_C7FF;
    endtask

    task automatic cfg_rd(input logic [11:0] a, input logic [63:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, $sformatf("read @%h", a), cfg_rdata, exp);
    endtask

    // behavioural model: kind 0 fault, 1 direct, 2 table
    function automatic void model(input logic [63:0] a, output int kind,
                                  output logic [63:0] ea, output logic [63:0] em);
        kind = 0; ea = 0; em = 0;
        if (a <= 64'hFFFF_FFFF) begin
            if (sh_ctl[5] && a >= 64'h8_0000 && a <= 64'hF_FFFF) return;
            for (int w = 0; w < 4; w++) begin
                logic [63:0] ext;
                ext = sh_mask[w] | 64'hF_FFFF;
                if (w == 3 && sh_base[3][39]) continue;
                if (sh_base[w][0] && ((a & ~ext) == (sh_base[w] & 64'hFFF0_0000))) begin
                    if (sh_base[w][1]) begin
                        kind = 2;
                        ea = (sh_tba[w] & ~(sh_mask[w] >> 10)) | ((a & (sh_mask[w] | 64'hF_E000)) >> 10);
                    end else begin
                        kind = 1;
                        ea = (sh_tba[w] & ~ext) | (a & ext);
                        em = ext;
                    end
                    return;
                end
            end
        end else if (a >= 64'h100_0000_0000 && a <= 64'h1FF_FFFF_FFFF && sh_ctl[6]) begin
            kind = 1; ea = a & 64'h7_FFFF_FFFF; em = 64'h7_FFFF_FFFF;
        end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF && sh_base[3][39] && sh_base[3][0]) begin
            kind = 2;
            ea = (sh_tba[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
        end
    endfunction

    // one translation, checked on every cycle from acceptance to idle
    task automatic xlate(input logic [63:0] a, input int rdy_dly, input int rsp_dly,
                         input logic [63:0] pte, input bit junk, input string req);
        int kind;
        logic [63:0] ea, em, ep, emk;
        logic eh;
        model(a, kind, ea, em);
        @(negedge clk);
        xl_valid = 1'b1; xl_addr = a;
        @(negedge clk);                                  // LOOKUP
        xl_valid = junk; xl_addr = ~a;
        chk("R11", "busy after accept", {63'b0, xl_busy}, 64'd1);
        chk("R11", "no early result", {63'b0, rsp_valid | mem_req_valid}, 64'd0);
        if (kind != 2) begin
            eh = (kind == 1); ep = ea; emk = em;
            @(negedge clk);
        end else begin
            @(negedge clk);                              // FETCH
            chk(req, "table read issued (R4)", {63'b0, mem_req_valid}, 64'd1);
            chk(req, "entry address (R4)", mem_req_addr, ea);
            for (int i = 0; i < rdy_dly; i++) begin
                @(negedge clk);
                chk("R4", "request held", {63'b0, mem_req_valid}, 64'd1);
                chk("R4", "address held", mem_req_addr, ea);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);                              // WAIT
            mem_req_ready = 1'b0;
            chk("R4", "single request", {63'b0, mem_req_valid | rsp_valid}, 64'd0);
            for (int i = 0; i < rsp_dly; i++) begin
                @(negedge clk);
                chk("R11", "waiting for entry", {63'b0, rsp_valid}, 64'd0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = pte;
            @(negedge clk);                              // RESP
            mem_rsp_valid = 1'b0;
            eh  = pte[0];
            ep  = pte[0] ? (((pte & 64'h3F_FFFE) << 12) | (a & 64'h1FFF)) : 64'h0;
            emk = pte[0] ? 64'h1FFF : 64'h0;
        end
        chk(req, "result strobe", {63'b0, rsp_valid}, 64'd1);
        chk(req, "hit", {63'b0, rsp_hit}, {63'b0, eh});
        chk(req, "address", rsp_paddr, ep);
        chk(req, "mask", rsp_mask, emk);
        xl_valid = 1'b0;
        @(negedge clk);
        chk("R11", "idle after result", {62'b0, xl_busy, rsp_valid}, 64'd0);
    endtask

    initial begin
        #900000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            sh_base[i] = 0; sh_mask[i] = 0; sh_tba[i] = 0;
        end
        sh_base[3] = 64'h2; sh_ctl = 0;
        repeat (4) @(negedge clk);
        chk("R12", "outputs in reset", {61'b0, xl_busy, rsp_valid, mem_req_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "outputs after reset", {61'b0, xl_busy, rsp_valid, mem_req_valid}, 64'd0);

        // R1: reset values, keep masks, forced bit, unused offset
        cfg_rd(12'h0C0, 64'h2, "R1");
        cfg_rd(12'h000, 64'h0, "R1");
        cfg_wr(12'h000, '1);        cfg_rd(12'h000, 64'hFFF0_0003, "R1");
        cfg_wr(12'h0C0, '1);        cfg_rd(12'h0C0, 64'h80_FFF0_0003, "R1");
        cfg_wr(12'h0C0, 64'h0);     cfg_rd(12'h0C0, 64'h2, "R1");
        cfg_wr(12'h140, '1);        cfg_rd(12'h140, 64'hFFF0_0000, "R1");
        cfg_wr(12'h280, '1);        cfg_rd(12'h280, 64'h7_FFFF_FC00, "R1");
        cfg_wr(12'h300, '1);        cfg_rd(12'h300, 64'h1C_FF0F_C7FF, "R1");
        cfg_wr(12'h380, '1);        cfg_rd(12'h380, 64'h0, "R1");

        // programme windows
        cfg_wr(12'h300, 64'h0);
        cfg_wr(12'h000, 64'h4000_0001); cfg_wr(12'h100, 64'h0FF0_0000); cfg_wr(12'h200, 64'h1_2000_0000);
        cfg_wr(12'h040, 64'h8000_0003); cfg_wr(12'h140, 64'h0010_0000); cfg_wr(12'h240, 64'h4000);
        cfg_wr(12'h080, 64'h0);         cfg_wr(12'h180, 64'h0);         cfg_wr(12'h280, 64'h0);
        cfg_wr(12'h0C0, 64'hC000_0001); cfg_wr(12'h1C0, 64'h0);         cfg_wr(12'h2C0, 64'h1_0000_0000);

        xlate(64'h4123_4567, 0, 0, 0, 1'b0, "R3");                     // R2 R3 direct
        xlate(64'h8012_3456, 2, 3, 64'h3_5791, 1'b1, "R5");            // R4 R5 valid entry, R11 junk
        xlate(64'h8012_3456, 0, 1, 64'h3_5790, 1'b0, "R5");            // R5 invalid entry
        xlate(64'h5000_0000, 0, 0, 0, 1'b0, "R2");                     // R2 no window

        // R7 priority and enable
        cfg_wr(12'h080, 64'h4000_0001); cfg_wr(12'h180, 64'h0FF0_0000); cfg_wr(12'h280, 64'h2_0000_0000);
        xlate(64'h4000_0010, 0, 0, 0, 1'b0, "R7");
        cfg_wr(12'h000, 64'h4000_0000);
        xlate(64'h4000_0010, 0, 0, 0, 1'b0, "R7");
        xlate(64'hC001_2345, 1, 0, 64'h7_7771, 1'b0, "R7");             // window 3 narrow
        cfg_wr(12'h0C0, 64'h80_C000_0001);
        xlate(64'hC001_2345, 0, 0, 0, 1'b0, "R7");                     // bit 39 removes it

        // R9 wide table
        xlate(64'h8AB_1234_6000, 0, 0, 64'h12_3457, 1'b0, "R9");
        xlate(64'hFFF_FFFF_E000, 1, 1, 64'h1, 1'b0, "R9");
        cfg_wr(12'h0C0, 64'h80_C000_0000);
        xlate(64'h8AB_1234_6000, 0, 0, 0, 1'b0, "R9");

        // R8 pass-through region
        xlate(64'h123_4567_89AB, 0, 0, 0, 1'b0, "R8");
        cfg_wr(12'h300, 64'h40);
        xlate(64'h123_4567_89AB, 0, 0, 0, 1'b0, "R8");
        xlate(64'h200_0000_0000, 0, 0, 0, 1'b0, "R8");

        // R6 hole
        cfg_wr(12'h080, 64'h1); cfg_wr(12'h180, 64'h0); cfg_wr(12'h280, 64'h3_0000_0000);
        cfg_wr(12'h300, 64'h0);
        xlate(64'h9_0000, 0, 0, 0, 1'b0, "R6");
        cfg_wr(12'h300, 64'h20);
        xlate(64'h9_0000, 0, 0, 0, 1'b0, "R6");
        xlate(64'h8_0000, 0, 0, 0, 1'b0, "R6");
        xlate(64'h7_FFFF, 0, 0, 0, 1'b0, "R6");

        // R10 other
        xlate(64'h400_0000_0000, 0, 0, 0, 1'b0, "R10");
        xlate(64'h1_0000_0000, 0, 0, 0, 1'b0, "R10");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule